// File: doc/BRIEF.md
# Per-Channel Digital Gain With Dither

This block sits in a pixel pipeline after black-level correction. It takes a stream of signed 12-bit pixels. Each pixel is multiplied by a digital gain chosen by its position in a 2x2 colour mosaic. The gain is unsigned fixed point with 4 integer bits and 7 fraction bits, so it has 128 steps per doubling and tops out just under 16x. Before the 7 fraction bits are dropped, an optional pseudo-random value is added to them. This spreads the quantisation error from the gain instead of always rounding down. A data pedestal is then added, and the result is saturated into an unsigned 12-bit output.

The mosaic position is derived from two flags that travel with each pixel: first pixel of a frame and first pixel of a line. Rows of even index carry green/red, and rows of odd index carry blue/green. The four gains, the pedestal and the dither enable are plain level inputs. Their values are captured into internal copies only when a frame-start pixel is accepted. A frame is therefore always processed with one consistent set of settings. Until the first frame start, the internal copies hold reset defaults: unity gain, pedestal 168 and dither on.

Both stream sides use valid/ready. A pixel moves on a rising edge where valid and ready are both high. A source must hold its pixel and flags stable while valid is high and ready is low. Once `out_valid` is raised, it stays high with the pixel and flags unchanged until `out_ready` is seen high. With `out_ready` held high, one pixel per clock flows through.

Top module: `dg_channel_gain`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Pixels sent before any frame-start pixel use gain 128 (1.0) on every channel, pedestal 168 and dither enabled, whatever the live setting inputs show.
- R2: The output equals clamp(floor((x*g + d) / 128) + p, 0, 4095). Here x is the input as 12-bit two's complement, g is the selected 11-bit gain, d is the dither value and p is the pedestal. The floor rounds toward minus infinity.
- R3: Mosaic position: a pixel with `in_sof` is row 0, column 0. A pixel with `in_sol` but without `in_sof` flips the row parity and is column 0. Any other pixel flips the column parity. Position (row,col) selects the gain: (0,0) `gain_gr`, (0,1) `gain_r`, (1,0) `gain_b`, (1,1) `gain_gb`. Before any flag, the next pixel counts as (0,0).
- R4: The dither value is the low 7 bits of a 16-bit shift register. The register is seeded 0xACE1 at reset. After each accepted pixel it shifts left by one, and its new bit 0 is the XOR of its bits 15, 13, 12 and 10. When dither is disabled, d is 0 while the register still advances.
- R5: The gains, the pedestal and the dither enable are taken from the live inputs on a frame-start pixel, and that pixel already uses them. Changes on the live inputs in the middle of a frame do not affect the frame's remaining pixels.
- R6: Results below 0 become 0, and results above 4095 become 4095.
- R7: A pixel accepted on rising edge N appears on the outputs right after rising edge N+1, when the output is not stalled. `out_sof` and `out_sol` go with their own pixel.
- R8: While `out_valid` is high and `out_ready` is low, the output pixel and flags hold still. With both stages full, `in_ready` is low. No pixel is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | 12 | Input pixel, two's complement |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_sol | input | 1 | Pixel is the first of a line |
| gain_gr | input | 11 | Gain for green on red rows, 4.7 format |
| gain_r | input | 11 | Gain for red, 4.7 format |
| gain_b | input | 11 | Gain for blue, 4.7 format |
| gain_gb | input | 11 | Gain for green on blue rows, 4.7 format |
| pedestal | input | 12 | Offset added after the gain |
| dither_on | input | 1 | 1 enables dither |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the output pixel |
| out_pix | output | 12 | Output pixel, unsigned |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_sol | output | 1 | Output pixel is the first of a line |

## Verification
The assertions take for granted that the source follows the valid/ready rule, holding pixel and flags while it waits for `in_ready`. They also take for granted that a frame-start pixel is treated as the start of a row whatever `in_sol` shows. The stimulus changes inputs only a short time after a rising edge. It keeps a pixel and its flags in place until the edge on which `in_ready` was seen high, and it always sends frame-start pixels with `in_sol` set. The live setting inputs are changed freely between pixels, including in mid-frame, since the block is meant to ignore them there.

// File: rtl/dg_pkg.sv
package dg_pkg;

  // Mosaic position code: {row parity, column parity}
  typedef enum logic [1:0] {
    CH_GR = 2'b00,
    CH_R  = 2'b01,
    CH_B  = 2'b10,
    CH_GB = 2'b11
  } bayer_ch_e;

  localparam int NUM_CH = 4;
  localparam int LFSR_W = 16;

endpackage

// File: rtl/dg_bayer_phase.sv
module dg_bayer_phase
  import dg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      sof,
  input  logic      sol,
  output bayer_ch_e ch,
  output logic      row_q
);

  logic col_q;
  logic row_c;
  logic col_c;

  always_comb begin
    if (sof) begin
      row_c = 1'b0;
      col_c = 1'b0;
    end else if (sol) begin
      row_c = ~row_q;
      col_c = 1'b0;
    end else begin
      row_c = row_q;
      col_c = ~col_q;
    end
  end

  assign ch = bayer_ch_e'({row_c, col_c});

  // The column starts at 1 so that a flagless first pixel lands on (0,0)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= 1'b0;
      col_q <= 1'b1;
    end else if (adv) begin
      row_q <= row_c;
      col_q <= col_c;
    end
  end

endmodule

// File: rtl/dg_dither_lfsr.sv
module dg_dither_lfsr
  import dg_pkg::*;
#(
  parameter int                OUT_W = 7,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] dith
);

  logic [LFSR_W-1:0] st_q;
  logic              fb;

  assign fb   = st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10];
  assign dith = st_q[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else if (adv) st_q <= {st_q[LFSR_W-2:0], fb};
  end

endmodule

// File: rtl/dg_cfg_shadow.sv
module dg_cfg_shadow
  import dg_pkg::*;
#(
  parameter int GAIN_W    = 11,
  parameter int PIX_W     = 12,
  parameter int GAIN_ONE  = 128,
  parameter int PED_RESET = 168
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NUM_CH-1:0][GAIN_W-1:0] live_g,
  input  logic [PIX_W-1:0]              live_ped,
  input  logic                          live_dith,
  output logic [NUM_CH-1:0][GAIN_W-1:0] eff_g,
  output logic [PIX_W-1:0]              eff_ped,
  output logic                          eff_dith,
  output logic [PIX_W-1:0]              ped_q
);

  logic dith_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [GAIN_W-1:0] g_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_q <= GAIN_W'(GAIN_ONE);
      else if (load) g_q <= live_g[c];
    end
    assign eff_g[c] = load ? live_g[c] : g_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ped_q  <= PIX_W'(PED_RESET);
      dith_q <= 1'b1;
    end else if (load) begin
      ped_q  <= live_ped;
      dith_q <= live_dith;
    end
  end

  assign eff_ped  = load ? live_ped : ped_q;
  assign eff_dith = load ? live_dith : dith_q;

endmodule

// File: rtl/dg_pedestal_clamp.sv
module dg_pedestal_clamp #(
  parameter int SCL_W = 18,
  parameter int PIX_W = 12
) (
  input  logic signed [SCL_W-1:0] val,
  input  logic        [PIX_W-1:0] ped,
  output logic        [PIX_W-1:0] res
);

  localparam int T_W = SCL_W + 1;
  localparam logic signed [T_W-1:0] TOP = T_W'((1 << PIX_W) - 1);

  logic signed [T_W-1:0] tot;

  assign tot = T_W'(val) + T_W'(signed'({1'b0, ped}));

  always_comb begin
    if (tot[T_W-1]) res = '0;
    else if (tot > TOP) res = '1;
    else res = PIX_W'(tot);
  end

endmodule

// File: rtl/dg_channel_gain.sv
module dg_channel_gain
  import dg_pkg::*;
#(
  parameter int                PIX_W     = 12,
  parameter int                GAIN_INT  = 4,
  parameter int                GAIN_FRAC = 7,
  parameter int                PED_RESET = 168,
  parameter logic [LFSR_W-1:0] SEED      = 16'hACE1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic signed [PIX_W-1:0]                 in_pix,
  input  logic                                    in_sof,
  input  logic                                    in_sol,
  input  logic        [GAIN_INT+GAIN_FRAC-1:0]    gain_gr,
  input  logic        [GAIN_INT+GAIN_FRAC-1:0]    gain_r,
  input  logic        [GAIN_INT+GAIN_FRAC-1:0]    gain_b,
  input  logic        [GAIN_INT+GAIN_FRAC-1:0]    gain_gb,
  input  logic        [PIX_W-1:0]                 pedestal,
  input  logic                                    dither_on,
  output logic                                    out_valid,
  input  logic                                    out_ready,
  output logic        [PIX_W-1:0]                 out_pix,
  output logic                                    out_sof,
  output logic                                    out_sol
);

  localparam int GAIN_W   = GAIN_INT + GAIN_FRAC;
  localparam int GAIN_ONE = 1 << GAIN_FRAC;
  localparam int PROD_W   = PIX_W + GAIN_W + 1;
  localparam int SUM_W    = PROD_W + 1;
  localparam int SCL_W    = SUM_W - GAIN_FRAC;

  // Handshake
  logic acc;
  logic s2_ready;
  logic s1_v;

  assign s2_ready = ~out_valid | out_ready;
  assign in_ready = ~s1_v | s2_ready;
  assign acc      = in_valid & in_ready;

  // Frame-latched settings
  logic [NUM_CH-1:0][GAIN_W-1:0] live_g;
  logic [NUM_CH-1:0][GAIN_W-1:0] eff_g;
  logic [PIX_W-1:0]              eff_ped;
  logic                          eff_dith;
  logic [PIX_W-1:0]              ped_q;

  assign live_g = {gain_gb, gain_b, gain_r, gain_gr};

  dg_cfg_shadow #(
    .GAIN_W   (GAIN_W),
    .PIX_W    (PIX_W),
    .GAIN_ONE (GAIN_ONE),
    .PED_RESET(PED_RESET)
  ) i_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc & in_sof),
    .live_g   (live_g),
    .live_ped (pedestal),
    .live_dith(dither_on),
    .eff_g    (eff_g),
    .eff_ped  (eff_ped),
    .eff_dith (eff_dith),
    .ped_q    (ped_q)
  );

  // Mosaic position and dither source
  bayer_ch_e             ch;
  logic                  row_q;
  logic [GAIN_FRAC-1:0]  dith;

  dg_bayer_phase i_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (acc),
    .sof  (in_sof),
    .sol  (in_sol),
    .ch   (ch),
    .row_q(row_q)
  );

  dg_dither_lfsr #(
    .OUT_W(GAIN_FRAC),
    .SEED (SEED)
  ) i_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (acc),
    .dith (dith)
  );

  // Stage 1: multiply, add dither, drop the fraction (floor)
  logic        [GAIN_W-1:0]    g_sel;
  logic        [GAIN_FRAC-1:0] dith_g;
  logic signed [PROD_W-1:0]    prod;
  logic signed [SUM_W-1:0]     sum;
  logic signed [SCL_W-1:0]     scaled;

  assign g_sel  = eff_g[ch];
  assign dith_g = eff_dith ? dith : '0;
  assign prod   = PROD_W'(in_pix) * PROD_W'(signed'({1'b0, g_sel}));
  assign sum    = SUM_W'(prod) + SUM_W'(signed'({1'b0, dith_g}));
  assign scaled = SCL_W'(sum >>> GAIN_FRAC);

  logic signed [SCL_W-1:0] s1_val;
  logic        [PIX_W-1:0] s1_ped;
  logic                    s1_sof;
  logic                    s1_sol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_val <= '0;
      s1_ped <= '0;
      s1_sof <= 1'b0;
      s1_sol <= 1'b0;
    end else if (in_ready) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_val <= scaled;
        s1_ped <= eff_ped;
        s1_sof <= in_sof;
        s1_sol <= in_sol;
      end
    end
  end

  // Stage 2: pedestal and saturation
  logic [PIX_W-1:0] res;

  dg_pedestal_clamp #(
    .SCL_W(SCL_W),
    .PIX_W(PIX_W)
  ) i_clamp (
    .val(s1_val),
    .ped(s1_ped),
    .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
    end else if (s2_ready) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_pix <= res;
        out_sof <= s1_sof;
        out_sol <= s1_sol;
      end
    end
  end

endmodule

// File: rtl/dg_channel_gain_chk.sv
module dg_channel_gain_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             in_sol,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_sof,
  input logic             out_sol,
  input logic             s1_v,
  input logic             row_q,
  input logic [PIX_W-1:0] ped_q
);

  // R8: a stalled output holds its pixel and flags
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_sol));

  // R8: with both stages full and the sink stalled, no new pixel is taken
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && s1_v |-> !in_ready);

  // R7: an accepted pixel occupies the first stage on the next cycle
  a_r7_fill_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v);

  // R7: a first-stage pixel moves to the output when the output is free
  a_r7_fill_output: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && (!out_valid || out_ready) |=> out_valid);

  // R5: the held pedestal only changes on an accepted frame-start pixel
  a_r5_ped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> $stable(ped_q));

  // R3: a line-start pixel flips the row parity
  a_r3_row_flip: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sol && !in_sof |=> row_q != $past(row_q));

  // R3: a frame-start pixel returns to row 0
  a_r3_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sof |=> !row_q);

endmodule

bind dg_channel_gain dg_channel_gain_chk #(.PIX_W(PIX_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sof   (in_sof),
  .in_sol   (in_sol),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pix  (out_pix),
  .out_sof  (out_sof),
  .out_sol  (out_sol),
  .s1_v     (s1_v),
  .row_q    (row_q),
  .ped_q    (ped_q)
);

// File: tb/test_dg_channel_gain.sv
`timescale 1ns/1ps
module test_dg_channel_gain;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_pix = '0;
  logic        in_sof = 1'b0;
  logic        in_sol = 1'b0;
  logic [10:0] gain_gr = '0, gain_r = '0, gain_b = '0, gain_gb = '0;
  logic [11:0] pedestal = '0;
  logic        dither_on = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_pix;
  logic        out_sof, out_sol;

  always #5 clk = ~clk;

  dg_channel_gain i_dg_channel_gain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .in_sol(in_sol),
    .gain_gr(gain_gr), .gain_r(gain_r), .gain_b(gain_b), .gain_gb(gain_gb),
    .pedestal(pedestal), .dither_on(dither_on),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_sol(out_sol)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit [15:0] lfsr_m = 16'hACE1;

  int    obs_q[$];
  int    obsf_q[$];
  int    exp_q[$];
  int    expf_q[$];
  string lbl_q[$];

  // Columns: input, gain, pedestal, expected (dither off)
  localparam int NV = 12;
  localparam int VEC [NV][4] = '{
    '{  100,  128,  168,  268},
    '{  100,  192,    0,  150},
    '{  -50,  128,  168,  118},
    '{ -300,  128,  168,    0},
    '{  256, 2047,  168, 4095},
    '{    3, 2047,    0,   47},
    '{   -1,  192,   10,    8},
    '{ 2047,    0,    5,    5},
    '{ 2000,  256,    0, 4000},
    '{ 1000,  128, 4095, 4095},
    '{-2048, 2047, 4095,    0},
    '{    5,  255,    0,    9}
  };

  function automatic int model(int x, int g, int d, int p);
    int v;
    v = ((x * g + d) >>> 7) + p;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic int dnow(bit en);
    return en ? int'(lfsr_m[6:0]) : 0;
  endfunction

  task automatic chk(bit ok, string lb, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", lb, act, expv);
    end
  endtask

  task automatic set_all_gains(int g);
    gain_gr = 11'(g); gain_r = 11'(g); gain_b = 11'(g); gain_gb = 11'(g);
  endtask

  // Called shortly after a rising edge; returns shortly after the accepting edge
  task automatic send(int x, bit sof, bit sol, int e, string lb);
    in_pix = 12'(x); in_sof = sof; in_sol = sol; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    exp_q.push_back(e); expf_q.push_back({30'd0, sof, sol}); lbl_q.push_back(lb);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      obs_q.push_back(int'(out_pix));
      obsf_q.push_back({30'd0, out_sof, out_sol});
    end
  end

  task automatic drain_check();
    repeat (6) @(negedge clk);
    while (exp_q.size() > 0) begin
      string lb;
      int e, ef;
      lb = lbl_q.pop_front(); e = exp_q.pop_front(); ef = expf_q.pop_front();
      n_chk++;
      if (obs_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: actual no pixel expected %0d", lb, e);
      end else begin
        int a, af;
        a = obs_q.pop_front(); af = obsf_q.pop_front();
        if (a != e || af != ef) begin
          n_fail++;
          $display("FAIL %s: actual %0d flags %0d expected %0d flags %0d", lb, a, af, e, ef);
        end
      end
    end
    chk(obs_q.size() == 0, "R8 extra pixels", obs_q.size(), 0);
    obs_q.delete(); obsf_q.delete();
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #2;

    // R1: defaults before any frame start; live inputs differ on purpose
    set_all_gains(1024); pedestal = 12'd0; dither_on = 1'b0;
    send(100, 0, 0, model(100, 128, dnow(1), 168), "R1 default GR");
    send(100, 0, 0, model(100, 128, dnow(1), 168), "R1 default R");
    send(-40, 0, 0, model(-40, 128, dnow(1), 168), "R1 default third");
    drain_check();

    // R2 R6: table of single-pixel frames, dither off
    for (int i = 0; i < NV; i++) begin
      set_all_gains(VEC[i][1]); pedestal = 12'(VEC[i][2]); dither_on = 1'b0;
      send(VEC[i][0], 1, 1, VEC[i][3], $sformatf("R2 R6 vector %0d", i));
    end
    drain_check();

    // R3: channel selection across three lines; R5: mid-frame change ignored
    gain_gr = 11'd128; gain_r = 11'd256; gain_b = 11'd384; gain_gb = 11'd512;
    pedestal = 12'd0; dither_on = 1'b0;
    send(10, 1, 1, 10, "R3 row0 col0 GR");
    gain_r = 11'd1024; pedestal = 12'd100; dither_on = 1'b1;
    send(10, 0, 0, 20, "R5 R3 row0 col1 R keeps frame gain");
    send(10, 0, 1, 30, "R3 row1 col0 B");
    send(10, 0, 0, 40, "R3 row1 col1 GB");
    send(10, 0, 1, 10, "R3 row2 col0 GR");
    send(10, 0, 0, 20, "R3 row2 col1 R");
    pedestal = 12'd0; dither_on = 1'b0;
    send(10, 1, 1, 10, "R5 new frame GR");
    send(10, 0, 0, 80, "R5 new frame R picks up gain");
    drain_check();

    // R4: dither on, then off
    set_all_gains(1); pedestal = 12'd0; dither_on = 1'b1;
    for (int i = 0; i < 8; i++) begin
      int e;
      e = model(64, 1, dnow(1), 0);
      send(64, (i == 0), (i == 0), e, $sformatf("R4 dither on %0d", i));
    end
    dither_on = 1'b0;
    for (int i = 0; i < 4; i++)
      send(127, (i == 0), (i == 0), 0, $sformatf("R4 dither off %0d", i));
    drain_check();

    // R7: latency with an idle pipeline
    set_all_gains(128); pedestal = 12'd7; dither_on = 1'b0;
    send(3, 1, 1, 10, "R7 pixel value");
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 not yet after acceptance edge", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R7 valid after next edge", int'(out_valid), 1);
    chk(out_pix == 12'd10, "R7 data after next edge", int'(out_pix), 10);
    chk(out_sof == 1'b1, "R7 frame flag follows pixel", int'(out_sof), 1);
    drain_check();

    // R8: back-pressure
    pedestal = 12'd0;
    out_ready = 1'b0;
    send(1, 1, 1, 1, "R8 order first");
    send(2, 0, 0, 2, "R8 order second");
    fork
      send(3, 0, 0, 3, "R8 order third");
      begin
        int held;
        @(negedge clk);
        held = int'(out_pix);
        chk(held == 1, "R8 stalled output value", held, 1);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R8 in_ready low when full", int'(in_ready), 0);
        chk(out_valid == 1'b1, "R8 out_valid held", int'(out_valid), 1);
        chk(int'(out_pix) == held, "R8 output stable while stalled", int'(out_pix), held);
        @(posedge clk); #2;
        out_ready = 1'b1;
      end
    join
    drain_check();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule